// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

The block holds two timer/counters. Each one keeps a low and a high count byte and works in one of four modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, or a split mode. A small register port lets software write and read two control bytes and the four count bytes. The first control byte holds the run and flag bits. The second holds the mode, source and gate bits.

Each count step comes from one of two sources. The first is an internal tick, which runs at one twelfth, one quarter, or the whole of the system clock rate. The second is a falling edge on that timer's external count pin. A gate pin can also hold the timer still. When a timer overflows, it raises a sticky flag. The flag clears when the interrupt controller acknowledges it. The second timer also emits a one-cycle overflow pulse for a serial baud generator.

Each timer's mode field acts as a four-state machine with these states:
- `CM_WIDE13` is the 13-bit counter.
- `CM_FULL16` is the 16-bit counter.
- `CM_RELOAD8` is the 8-bit counter that reloads.
- `CM_SPLIT` is the split mode.

Every transition between states is a software write to the mode byte, and any state can move to any other. Overflow transitions inside a state are: wrap-to-zero in `CM_WIDE13` and `CM_FULL16`, reload-from-high in `CM_RELOAD8`, and per-byte wrap in `CM_SPLIT`.

Top module: `dual_tc`

## Requirements
- R1: Register addresses are 0 = control, 1 = mode, 2 = timer0 low, 3 = timer0 high, 4 = timer1 low, 5 = timer1 high. Control bits are: bit0 run0, bit1 flag0, bit2 run1, bit3 flag1. Mode bits for timer n, at offset 4n, are: [1:0] mode (00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split), [2] external count select, [3] gate enable. After reset all six registers read zero and both flag outputs are low.
- R2: In 16-bit mode, each enabled step adds one to {high,low}. Going from FFFFh to 0000h sets the flag, and counting then carries on from zero.
- R3: In 13-bit mode, the count is {high, low[4:0]}. Low bits [7:5] never change because of counting. A step from 1FFFh wraps to zero and sets the flag.
- R4: In 8-bit reload mode, only the low byte counts. A step from FFh loads the low byte from the high byte and sets the flag. The high byte does not change.
- R5: With gate enable at 0, the run bit alone lets the timer count. With gate enable at 1, the timer also needs its gate pin to be high.
- R6: With external count select at 1, the timer advances by exactly one for each falling edge on its count pin, and internal ticks have no effect.
- R7: In timer0 split mode, timer0's low byte is an 8-bit counter that uses run0 and flag0. Timer0's high byte is an 8-bit counter on timer0's internal tick that uses run1 and sets flag1 when it wraps from FFh.
- R8: Timer1 in split mode holds its count. While timer0 is split, timer1 (if not itself split) counts without needing run1 and never sets flag1.
- R9: A flag clears on its acknowledge strobe. Software can set or clear a flag by writing the control byte.
- R10: The internal tick comes once every 12 clocks in standard rate, once every 4 clocks in fast rate, and on every clock when fast rate and the global turbo input are both set.
- R11: When software writes a count byte in the same cycle that the counter would step, the written value is kept.
- R12: Every timer1 overflow produces a one-cycle pulse on `t1_ovf_pulse`, in the same cycle its flag would rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| fast_sel | input | 2 | Per-timer fast tick select |
| turbo | input | 1 | Global undivided-clock select for fast timers |
| cnt_pin | input | 2 | External count pins, falling edge counted |
| gate_pin | input | 2 | Gate pins, high lets a gated timer run |
| int_ack | input | 2 | Per-timer interrupt acknowledge strobes |
| ovf_flag | output | 2 | Sticky overflow flags |
| t1_ovf_pulse | output | 1 | One-cycle timer1 overflow pulse |

## Verification
The assertions assume two things: pins that are held steady for at least two clocks between changes, and a wrap or reload check that applies only when no software write lands on the same cycle. The stimulus therefore holds each pin level for two clocks and lets the synchronizers settle before it starts or reads a timer. It also writes count bytes only while the counter is stopped, except in the single case where a write colliding with a step is itself the subject of the test. The count sweeps preload values three to four steps short of a wrap, so that every pulse count crosses the overflow boundary at a known step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CM_WIDE13  = 2'b00,
        CM_FULL16  = 2'b01,
        CM_RELOAD8 = 2'b10,
        CM_SPLIT   = 2'b11
    } cnt_mode_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RA_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] RA_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] RA_LO0  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_HI0  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_LO1  = 3'd4;
    localparam logic [ADDR_W-1:0] RA_HI1  = 3'd5;

    // Field offsets inside one timer's nibble of the mode byte
    localparam int MF_MODE = 0;
    localparam int MF_EXT  = 2;
    localparam int MF_GATE = 3;
    localparam int MF_SPAN = 4;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int N_TMR    = 2,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TMR-1:0] fast_sel,
    input  logic             turbo,
    output logic [N_TMR-1:0] tick
);
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
    localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);

    logic [SW-1:0] slow_cnt;
    logic [FW-1:0] fast_cnt;
    logic          slow_tick;
    logic          fast_tick;

    assign slow_tick = (slow_cnt == SLOW_LAST);
    assign fast_tick = (fast_cnt == FAST_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_cnt <= '0;
            fast_cnt <= '0;
        end else begin
            slow_cnt <= slow_tick ? '0 : slow_cnt + SW'(1);
            fast_cnt <= fast_tick ? '0 : fast_cnt + FW'(1);
        end
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_sel
        assign tick[i] = fast_sel[i] ? (turbo ? 1'b1 : fast_tick) : slow_tick;
    end

    if (SLOW_DIV > 1) begin : g_slow_chk
        // R10: the standard tick never fires on two adjacent cycles
        a_r10_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            slow_tick |=> !slow_tick);
    end

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int  STAGES      = 2,
    parameter bit  DETECT_FALL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic sig
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    if (DETECT_FALL) begin : g_fall
        assign sig = last_q & ~sync_q[STAGES-1];
        // R6: an edge strobe lasts one cycle
        a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            sig |=> !sig);
    end else begin : g_level
        assign sig = sync_q[STAGES-1];
    end

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int LOW_W    = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cnt_mode_e         mode,
    input  logic              adv,
    input  logic              adv_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf,
    output logic              ovf_hi
);
    localparam int NARROW_W = BYTE_W + LOW_W;
    localparam int WIDE_W   = 2 * BYTE_W;

    logic [NARROW_W-1:0] narrow_sum;
    logic [WIDE_W-1:0]   wide_sum;
    logic [BYTE_W-1:0]   lo_nxt;
    logic [BYTE_W-1:0]   hi_nxt;

    assign narrow_sum = {hi, lo[LOW_W-1:0]} + NARROW_W'(1);
    assign wide_sum   = {hi, lo} + WIDE_W'(1);

    // Next-count and overflow decode, one branch per mode state
    always_comb begin
        lo_nxt = lo;
        hi_nxt = hi;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            CM_WIDE13: begin
                if (adv) begin
                    lo_nxt = {lo[BYTE_W-1:LOW_W], narrow_sum[LOW_W-1:0]};
                    hi_nxt = narrow_sum[NARROW_W-1:LOW_W];
                    ovf    = &{hi, lo[LOW_W-1:0]};
                end
            end
            CM_FULL16: begin
                if (adv) begin
                    {hi_nxt, lo_nxt} = wide_sum;
                    ovf              = &{hi, lo};
                end
            end
            CM_RELOAD8: begin
                if (adv) begin
                    if (&lo) begin
                        lo_nxt = hi;
                        ovf    = 1'b1;
                    end else begin
                        lo_nxt = lo + BYTE_W'(1);
                    end
                end
            end
            CM_SPLIT: begin
                if (SPLIT_OK) begin
                    if (adv) begin
                        lo_nxt = lo + BYTE_W'(1);
                        ovf    = &lo;
                    end
                    if (adv_hi) begin
                        hi_nxt = hi + BYTE_W'(1);
                        ovf_hi = &hi;
                    end
                end
            end
            default: begin
                lo_nxt = lo;
            end
        endcase
    end

    // Count registers: a software write to a byte takes precedence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wr_data : lo_nxt;
            hi <= wr_hi ? wr_data : hi_nxt;
        end
    end

    a_r2_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_FULL16 && adv && (&{hi, lo}) && !wr_lo && !wr_hi)
        |=> (lo == '0 && hi == '0));

    a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_WIDE13 && !wr_lo)
        |=> (lo[BYTE_W-1:LOW_W] == $past(lo[BYTE_W-1:LOW_W])));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_RELOAD8 && adv && (&lo) && !wr_lo && !wr_hi)
        |=> (lo == $past(hi) && $stable(hi)));

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo == $past(wr_data)));

    if (!SPLIT_OK) begin : g_halt_chk
        a_r8_split_halts: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == CM_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
    end

endmodule

// File: rtl/dual_tc.sv
module dual_tc
    import tmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int LOW_W    = 5,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [1:0]        fast_sel,
    input  logic              turbo,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        int_ack,
    output logic [1:0]        ovf_flag,
    output logic              t1_ovf_pulse
);
    localparam int N_TMR  = 2;
    localparam int MODE_W = N_TMR * MF_SPAN;

    logic [N_TMR-1:0]  run_q;
    logic [N_TMR-1:0]  flag_q;
    logic [MODE_W-1:0] mode_q;
    logic              pulse_q;

    logic [N_TMR-1:0]  tick;
    logic [N_TMR-1:0]  pin_fall;
    logic [N_TMR-1:0]  gate_lvl;
    logic [N_TMR-1:0]  adv;
    logic [N_TMR-1:0]  ovf;
    logic [N_TMR-1:0]  ovf_hi;
    logic [N_TMR-1:0]  wr_lo;
    logic [N_TMR-1:0]  wr_hi;
    logic [N_TMR-1:0]  gate_ok;
    logic [N_TMR-1:0]  step_src;
    logic [N_TMR-1:0]  flag_set;
    logic [BYTE_W-1:0] lo_q [N_TMR];
    logic [BYTE_W-1:0] hi_q [N_TMR];
    cnt_mode_e         mode_t [N_TMR];

    logic ctrl_wr;
    logic mode_wr;
    logic split0;
    logic adv_hi0;

    assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);
    assign mode_wr = wr_en && (wr_addr == RA_MODE);
    assign wr_lo   = {wr_en && (wr_addr == RA_LO1), wr_en && (wr_addr == RA_LO0)};
    assign wr_hi   = {wr_en && (wr_addr == RA_HI1), wr_en && (wr_addr == RA_HI0)};

    tmr_tick_gen #(
        .N_TMR   (N_TMR),
        .SLOW_DIV(SLOW_DIV),
        .FAST_DIV(FAST_DIV)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_sel(fast_sel),
        .turbo   (turbo),
        .tick    (tick)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        tmr_pin_sync #(.STAGES(SYNC_LEN), .DETECT_FALL(1'b1)) u_cnt_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (cnt_pin[i]),
            .sig  (pin_fall[i])
        );
        tmr_pin_sync #(.STAGES(SYNC_LEN), .DETECT_FALL(1'b0)) u_gate_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (gate_pin[i]),
            .sig  (gate_lvl[i])
        );

        assign mode_t[i]   = cnt_mode_e'(mode_q[i*MF_SPAN+MF_MODE +: 2]);
        assign gate_ok[i]  = !mode_q[i*MF_SPAN+MF_GATE] || gate_lvl[i];
        assign step_src[i] = mode_q[i*MF_SPAN+MF_EXT] ? pin_fall[i] : tick[i];

        tmr_count_unit #(
            .BYTE_W  (BYTE_W),
            .LOW_W   (LOW_W),
            .SPLIT_OK(i == 0)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode_t[i]),
            .adv    (adv[i]),
            .adv_hi ((i == 0) ? adv_hi0 : 1'b0),
            .wr_lo  (wr_lo[i]),
            .wr_hi  (wr_hi[i]),
            .wr_data(wr_data),
            .lo     (lo_q[i]),
            .hi     (hi_q[i]),
            .ovf    (ovf[i]),
            .ovf_hi (ovf_hi[i])
        );
    end

    // Run decisions; timer0 split borrows run1 for its high byte
    assign split0  = (mode_t[0] == CM_SPLIT);
    assign adv[0]  = run_q[0] && gate_ok[0] && step_src[0];
    assign adv[1]  = (split0 || run_q[1]) && gate_ok[1] && step_src[1];
    assign adv_hi0 = run_q[1] && tick[0];

    // The second unit never raises ovf_hi; it is folded in for symmetry
    assign flag_set[0] = ovf[0];
    assign flag_set[1] = (split0 ? ovf_hi[0] : ovf[1]) | ovf_hi[1];

    // Control and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            mode_q <= '0;
        end else begin
            if (ctrl_wr) run_q  <= {wr_data[2], wr_data[0]};
            if (mode_wr) mode_q <= wr_data[MODE_W-1:0];
        end
    end

    // Flags: software write, then hardware set, then acknowledge clear
    for (genvar i = 0; i < N_TMR; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flag_q[i] <= 1'b0;
            else if (ctrl_wr)     flag_q[i] <= wr_data[2*i+1];
            else if (flag_set[i]) flag_q[i] <= 1'b1;
            else if (int_ack[i])  flag_q[i] <= 1'b0;
        end

        // R9: an acknowledge with no competing event leaves the flag clear
        a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (int_ack[i] && !flag_set[i] && !ctrl_wr) |=> !flag_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= ovf[1];
    end

    assign ovf_flag     = flag_q;
    assign t1_ovf_pulse = pulse_q;

    // Register read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            RA_CTRL: rd_data = BYTE_W'({flag_q[1], run_q[1], flag_q[0], run_q[0]});
            RA_MODE: rd_data = BYTE_W'(mode_q);
            RA_LO0:  rd_data = lo_q[0];
            RA_HI0:  rd_data = hi_q[0];
            RA_LO1:  rd_data = lo_q[1];
            RA_HI1:  rd_data = hi_q[1];
            default: rd_data = '0;
        endcase
    end

    a_r7_split_hi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (split0 && !run_q[1] && !wr_hi[0]) |=> $stable(hi_q[0]));

    a_r12_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[1] && !split0 && !ctrl_wr) |=> (t1_ovf_pulse && ovf_flag[1]));

endmodule

// File: tb/dual_tc_tb.sv
module dual_tc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] fast_sel = 2'b11;
    logic       turbo = 1'b1;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] int_ack = 2'b00;
    logic [1:0] ovf_flag;
    logic       t1_ovf_pulse;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    logic [7:0] d, d2;

    localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_LO0 = 3'd2,
                           A_HI0 = 3'd3, A_LO1 = 3'd4, A_HI1 = 3'd5;

    dual_tc u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fast_sel(fast_sel), .turbo(turbo), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .int_ack(int_ack), .ovf_flag(ovf_flag),
        .t1_ovf_pulse(t1_ovf_pulse)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (t1_ovf_pulse) pulse_cnt = pulse_cnt + 1;

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL timeout: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the next rising edge performs the write
    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic pin_pulse(input int i);
        cnt_pin[i] = 1'b0;
        repeat (2) @(negedge clk);
        cnt_pin[i] = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Start with ctrl value, let n counting edges pass in total, then stop
    task automatic run_window(input logic [7:0] go, input int n);
        wr(A_CTRL, go);
        repeat (n - 1) @(negedge clk);
        wr(A_CTRL, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and both flags
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 reset register", d, 0);
        end
        check("R1 reset flags", ovf_flag, 0);

        // Sweep: both timers, three counting modes, 1..6 external edges.
        // Turbo ticks run every cycle, so any leak of the internal tick shows (R6).
        for (int t = 0; t < 2; t++) begin
            for (int m = 0; m < 3; m++) begin
                for (int p = 1; p < 7; p++) begin
                    int v, e_lo, e_hi;
                    logic [2:0] alo, ahi;
                    alo = (t == 0) ? A_LO0 : A_LO1;
                    ahi = (t == 0) ? A_HI0 : A_HI1;
                    wr(A_MODE, 8'((m | 4) << (4 * t)));
                    wr(alo, (m == 0) ? 8'hFC : 8'hFC);
                    wr(ahi, (m == 2) ? 8'h30 : 8'hFF);
                    pulse_cnt = 0;
                    wr(A_CTRL, (t == 0) ? 8'h01 : 8'h04);
                    for (int k = 0; k < p; k++) pin_pulse(t);
                    repeat (4) @(negedge clk);
                    if (m == 0) begin
                        v = (32'h1FFC + p) & 32'h1FFF;
                        e_lo = 32'hE0 | (v & 32'h1F);
                        e_hi = (v >> 5) & 32'hFF;
                    end else if (m == 1) begin
                        v = (32'hFFFC + p) & 32'hFFFF;
                        e_lo = v & 32'hFF;
                        e_hi = v >> 8;
                    end else begin
                        e_lo = (p < 4) ? (32'hFC + p) : (32'h30 + p - 4);
                        e_hi = 32'h30;
                    end
                    rd(alo, d);
                    check((m == 0) ? "R3 low byte" : (m == 1) ? "R2/R6 low byte" : "R4 low byte", d, e_lo);
                    rd(ahi, d);
                    check((m == 0) ? "R3 high byte" : (m == 1) ? "R2 high byte" : "R4 high byte", d, e_hi);
                    check("R2 R3 R4 overflow flag", ovf_flag[t], (p >= 4) ? 1 : 0);
                    if (t == 1) check("R12 baud pulses", pulse_cnt, (p >= 4) ? 1 : 0);
                    wr(A_CTRL, 8'h00);
                end
            end
        end

        // R10: internal tick rates over a 120-edge window, timer0 16-bit
        wr(A_MODE, 8'h01);
        for (int c = 0; c < 3; c++) begin
            fast_sel = (c > 0) ? 2'b11 : 2'b00;
            turbo = (c == 2);
            wr(A_LO0, 8'h00);
            wr(A_HI0, 8'h00);
            run_window(8'h01, 120);
            rd(A_LO0, d); rd(A_HI0, d2);
            check("R10 tick rate", {d2, d}, (c == 0) ? 10 : (c == 1) ? 30 : 120);
        end
        fast_sel = 2'b11; turbo = 1'b1;

        // R5: gating
        wr(A_MODE, 8'h09);
        wr(A_LO0, 8'h00);
        wr(A_HI0, 8'h00);
        gate_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        run_window(8'h01, 20);
        rd(A_LO0, d);
        check("R5 gated, pin low", d, 0);
        gate_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        run_window(8'h01, 20);
        rd(A_LO0, d);
        check("R5 gated, pin high", d, 20);
        gate_pin[0] = 1'b0;
        wr(A_MODE, 8'h01);
        repeat (4) @(negedge clk);
        run_window(8'h01, 20);
        rd(A_LO0, d);
        check("R5 ungated, pin low", d, 40);

        // R11: write collides with a running step
        wr(A_LO0, 8'h00);
        wr(A_HI0, 8'h00);
        wr(A_CTRL, 8'h01);
        repeat (3) @(negedge clk);
        wr(A_LO0, 8'h40);
        repeat (2) @(negedge clk);
        wr(A_CTRL, 8'h00);
        rd(A_LO0, d);
        check("R11 write wins low", d, 8'h43);
        rd(A_HI0, d);
        check("R11 high untouched", d, 0);

        // R9: software set, readback, acknowledge clear
        wr(A_CTRL, 8'h0A);
        check("R9 software set", ovf_flag, 2'b11);
        rd(A_CTRL, d);
        check("R9 control readback", d, 8'h0A);
        int_ack = 2'b01;
        @(negedge clk);
        int_ack = 2'b00;
        check("R9 ack0 clears only flag0", ovf_flag, 2'b10);
        int_ack = 2'b10;
        @(negedge clk);
        int_ack = 2'b00;
        check("R9 ack1 clears flag1", ovf_flag, 2'b00);
        wr(A_CTRL, 8'h02);
        wr(A_CTRL, 8'h00);
        check("R9 software clear", ovf_flag, 2'b00);

        // R7: timer0 split, low byte on external edges with run0
        wr(A_MODE, 8'h07);
        wr(A_LO0, 8'hFE);
        wr(A_HI0, 8'hF0);
        wr(A_LO1, 8'h00);
        wr(A_HI1, 8'h00);
        wr(A_CTRL, 8'h01);
        for (int k = 0; k < 3; k++) pin_pulse(0);
        repeat (4) @(negedge clk);
        rd(A_LO0, d);
        check("R7 split low byte", d, 8'h01);
        rd(A_HI0, d);
        check("R7 split high idle without run1", d, 8'hF0);
        check("R7 flag0 from low byte", ovf_flag, 2'b01);
        rd(A_LO1, d); rd(A_HI1, d2);
        check("R8 timer1 runs without run1", ((d | d2) != 0) ? 1 : 0, 1);

        // R7: split high byte uses run1 and flag1
        wr(A_CTRL, 8'h00);
        wr(A_HI0, 8'hFD);
        wr(A_CTRL, 8'h04);
        repeat (3) @(negedge clk);
        check("R7 flag1 from high byte", ovf_flag[1], 1);
        wr(A_CTRL, 8'h00);
        rd(A_HI0, d);
        check("R7 split high byte count", d, 8'h01);

        // R8: timer1 overflows while timer0 is split: pulse, no flag1
        wr(A_MODE, 8'h13);
        wr(A_HI1, 8'hFF);
        wr(A_LO1, 8'hF0);
        pulse_cnt = 0;
        repeat (40) @(negedge clk);
        check("R8 R12 pulse while split", pulse_cnt, 1);
        check("R8 flag1 untouched", ovf_flag[1], 0);

        // R8: timer1 in split mode holds
        wr(A_MODE, 8'h31);
        wr(A_LO1, 8'h55);
        wr(A_HI1, 8'h66);
        wr(A_CTRL, 8'h04);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 8'h00);
        rd(A_LO1, d);
        check("R8 timer1 split holds low", d, 8'h55);
        rd(A_HI1, d);
        check("R8 timer1 split holds high", d, 8'h66);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule